// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on a MAC receive byte stream, ahead of the frame buffer. It reads the destination address at the head of every frame and decides whether to keep the frame or discard it. Three separately enabled rules can discard a frame: a unicast address that is not the station's own, the all-ones broadcast address, and multicast addresses. It can also cut frames that run past a programmable byte limit, remove the trailing four CRC bytes, and either report or ignore a CRC failure signalled from upstream.

Bytes pass through a six-byte delay line. The keep-or-discard verdict is known once the sixth destination byte arrives, so a discarded frame never shows a single byte at the output. When a frame ends, the bytes still in the line are drained on the following cycles. When stripping is enabled, only the two bytes that are not CRC are drained. The input must therefore leave at least six idle cycles between the last byte of one frame and the first byte of the next, which any Ethernet inter-frame gap satisfies. Configuration is static while frames flow.

Top module: `rx_da_filter`

## Requirements
- R1: The station address byte that arrives first on the wire is `cfg_addr_lo[7:0]`. The following bytes are `cfg_addr_lo[15:8]`, `[23:16]` and `[31:24]`, then `cfg_addr_hi[7:0]` and `cfg_addr_hi[15:8]`. A unicast frame carrying exactly this address is passed even when unicast discard is on.
- R2: With `cfg_addr_hi[16]` set, a unicast frame (bit 0 of the first destination byte is zero) whose address differs from the station address is dropped. With the bit clear, such a frame is passed.
- R3: With `cfg_addr_hi[17]` set, a frame addressed to FF:FF:FF:FF:FF:FF is dropped. Broadcast is never treated as unicast or multicast.
- R4: With `cfg_addr_hi[18]` set, a frame whose first destination byte has bit 0 set is dropped unless its address is all ones.
- R5: Each frame of six or more bytes produces exactly one `out_verdict` pulse, one cycle after its sixth byte, with `out_drop` set for a discard. A dropped frame emits no output beats. An accepted frame emits its bytes in order, with `out_sof` on the first beat and `out_eof` on the last.
- R6: A frame that ends before its sixth byte is dropped. A verdict pulse with `out_drop` set follows its last byte, and no output beats appear.
- R7: With `cfg_addr_hi[19]` set, a frame longer than `cfg_max_len` bytes (counting its CRC) is cut to exactly `cfg_max_len` output bytes, and `out_err` is set on its last beat. A frame of exactly `cfg_max_len` bytes is untouched. With the bit clear, no length limit applies. `cfg_max_len` must be at least 6.
- R8: With `cfg_addr_hi[20]` set, the last four bytes of each frame that ends normally are not output. A six-byte frame yields two beats.
- R9: `in_crc_err`, sampled with the last input byte, sets `out_err` on the last output beat, unless `cfg_addr_hi[21]` is set. `out_err` is never set on any other beat.
- R10: Idle cycles inside a frame (`in_valid` low) do not alter the output byte sequence.
- R11: After reset, `out_valid` and `out_verdict` are low until a frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_lo | input | 32 | Station address bytes 0..3 (byte 0 in the low bits) |
| cfg_addr_hi | input | 32 | Station address bytes 4..5 in [15:0]; control bits in [21:16] |
| cfg_max_len | input | 14 | Maximum frame length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | CRC failure, meaningful with in_eof |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_err | output | 1 | Frame error, only with out_eof |
| out_verdict | output | 1 | Verdict pulse, one per frame |
| out_drop | output | 1 | Verdict is discard |

## Verification
Two events can fall on the same input beat: the length cut and the end of the frame. They collide when a frame is exactly one byte longer than the limit. The address decision and the end of the frame also collide when a frame is exactly six bytes long. The bench sends a frame of `cfg_max_len + 1` bytes and a six-byte frame with stripping on. A reference model predicts the beat stream and verdicts, and every output beat is compared against it. The judged results are a cut to the limit with the error flag and a clean start of the next frame in the first case, and a verdict plus a two-beat drain in the second.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = 32;

  // control bit positions inside the upper configuration word
  localparam int HI_DISC_UC   = 16;
  localparam int HI_DISC_BC   = 17;
  localparam int HI_DISC_MC   = 18;
  localparam int HI_LEN_CHK   = 19;
  localparam int HI_CRC_STRIP = 20;
  localparam int HI_CRC_IGN   = 21;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_PASS,
    ST_DROP,
    ST_DRAIN
  } rxf_state_e;

  typedef struct packed {
    logic disc_uc;
    logic disc_bc;
    logic disc_mc;
    logic len_chk;
    logic crc_strip;
    logic crc_ign;
  } rxf_ctl_t;

  function automatic rxf_ctl_t unpack_ctl(input logic [CFG_W-1:0] hi);
    rxf_ctl_t c;
    c.disc_uc   = hi[HI_DISC_UC];
    c.disc_bc   = hi[HI_DISC_BC];
    c.disc_mc   = hi[HI_DISC_MC];
    c.len_chk   = hi[HI_LEN_CHK];
    c.crc_strip = hi[HI_CRC_STRIP];
    c.crc_ign   = hi[HI_CRC_IGN];
    return c;
  endfunction
endpackage

// File: rtl/rxf_delay_line.sv
module rxf_delay_line #(
  parameter int DEPTH = 6,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               shift_en,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] taps
);
  // tap 0 is the newest byte, tap DEPTH-1 the oldest
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (shift_en) stage_q[0] <= din;
  end

  genvar k;
  generate
    for (k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (shift_en) stage_q[k] <= stage_q[k-1];
      end
    end
    for (k = 0; k < DEPTH; k++) begin : g_tap
      assign taps[k*W +: W] = stage_q[k];
    end
  endgenerate
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
  import rxf_pkg::*;
#(
  parameter int NB = 6
) (
  input  logic [NB*BYTE_W-1:0] da,       // byte i (wire order) at [i*8 +: 8]
  input  logic [NB*BYTE_W-1:0] station,
  input  rxf_ctl_t             ctl,
  output logic                 reject
);
  logic [NB-1:0] byte_eq;
  logic [NB-1:0] byte_ff;

  genvar i;
  generate
    for (i = 0; i < NB; i++) begin : g_cmp
      assign byte_eq[i] = (da[i*BYTE_W +: BYTE_W] == station[i*BYTE_W +: BYTE_W]);
      assign byte_ff[i] = &da[i*BYTE_W +: BYTE_W];
    end
  endgenerate

  logic is_bc, is_mc, is_uc, is_hit;

  always_comb begin
    is_bc  = &byte_ff;                 // R3
    is_mc  = da[0] & ~is_bc;           // R4
    is_uc  = ~da[0];                   // R2
    is_hit = &byte_eq;                 // R1
    reject = (ctl.disc_bc & is_bc) |
             (ctl.disc_mc & is_mc) |
             (ctl.disc_uc & is_uc & ~is_hit);
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DA_BYTES  = 6,
  parameter int CRC_BYTES = 4,
  parameter int LEN_W     = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  rxf_ctl_t                   ctl,
  input  logic [LEN_W-1:0]           max_len,
  input  logic                       in_valid,
  input  logic [BYTE_W-1:0]          in_data,
  input  logic                       in_sof,
  input  logic                       in_eof,
  input  logic                       in_crc_err,
  input  logic                       reject,
  input  logic [DA_BYTES*BYTE_W-1:0] taps,
  output logic                       shift_en,
  output logic [BYTE_W-1:0]          shift_din,
  output logic                       out_valid,
  output logic [BYTE_W-1:0]          out_data,
  output logic                       out_sof,
  output logic                       out_eof,
  output logic                       out_err,
  output logic                       out_verdict,
  output logic                       out_drop
);
  localparam int DL_W = $clog2(DA_BYTES + 1);
  localparam logic [DL_W-1:0] DRAIN_FULL  = DL_W'(DA_BYTES);
  localparam logic [DL_W-1:0] DRAIN_STRIP = DL_W'(DA_BYTES - CRC_BYTES);
  localparam logic [LEN_W-1:0] LAST_DA    = LEN_W'(DA_BYTES - 1);

  rxf_state_e        st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [DL_W-1:0]   dl_q, dl_d;
  logic              skip_q, skip_d;
  logic              first_q, first_d;
  logic              err_q, err_d;
  logic              ov_d, os_d, oe_d, oerr_d, vv_d, vd_d;
  logic [BYTE_W-1:0] od_d;
  logic [BYTE_W-1:0] oldest;
  logic [LEN_W-1:0]  cnt_inc;
  logic              end_err;
  logic [DL_W-1:0]   drain_len;

  assign oldest    = taps[(DA_BYTES-1)*BYTE_W +: BYTE_W];
  assign cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign end_err   = in_crc_err & ~ctl.crc_ign;                 // R9
  assign drain_len = ctl.crc_strip ? DRAIN_STRIP : DRAIN_FULL;  // R8

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    dl_d      = dl_q;
    skip_d    = skip_q;
    first_d   = first_q;
    err_d     = err_q;
    shift_en  = 1'b0;
    shift_din = in_data;
    ov_d      = 1'b0;
    od_d      = oldest;
    os_d      = 1'b0;
    oe_d      = 1'b0;
    oerr_d    = 1'b0;
    vv_d      = 1'b0;
    vd_d      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid && in_sof) begin
          shift_en = 1'b1;
          cnt_d    = LEN_W'(1);
          if (in_eof) begin            // R6 single-byte runt
            vv_d = 1'b1;
            vd_d = 1'b1;
          end else begin
            st_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (in_valid) begin
          shift_en = 1'b1;
          cnt_d    = cnt_inc;
          if (cnt_q == LAST_DA) begin  // R5 sixth destination byte
            vv_d = 1'b1;
            vd_d = reject;
            if (reject) begin
              st_d = in_eof ? ST_IDLE : ST_DROP;
            end else begin
              first_d = 1'b1;
              if (in_eof) begin
                err_d  = end_err;
                dl_d   = drain_len;
                skip_d = 1'b0;
                st_d   = ST_DRAIN;
              end else begin
                st_d = ST_PASS;
              end
            end
          end else if (in_eof) begin   // R6
            vv_d = 1'b1;
            vd_d = 1'b1;
            st_d = ST_IDLE;
          end
        end
      end
      ST_PASS: begin
        if (in_valid) begin
          if (ctl.len_chk && cnt_q == max_len) begin  // R7 cut
            err_d  = 1'b1;
            dl_d   = DRAIN_FULL;
            skip_d = ~in_eof;
            st_d   = ST_DRAIN;
          end else begin
            shift_en = 1'b1;
            cnt_d    = cnt_inc;
            ov_d     = 1'b1;
            os_d     = first_q;
            first_d  = 1'b0;
            if (in_eof) begin
              err_d  = end_err;
              dl_d   = drain_len;
              skip_d = 1'b0;
              st_d   = ST_DRAIN;
            end
          end
        end
      end
      ST_DRAIN: begin
        shift_en  = 1'b1;
        shift_din = '0;
        ov_d      = 1'b1;
        os_d      = first_q;
        first_d   = 1'b0;
        dl_d      = dl_q - 1'b1;
        if (in_valid && in_eof) skip_d = 1'b0;
        if (dl_q == DL_W'(1)) begin
          oe_d   = 1'b1;
          oerr_d = err_q;
          st_d   = (skip_q && !(in_valid && in_eof)) ? ST_DROP : ST_IDLE;
        end
      end
      ST_DROP: begin
        if (in_valid && in_eof) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      dl_q        <= '0;
      skip_q      <= 1'b0;
      first_q     <= 1'b0;
      err_q       <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      out_err     <= 1'b0;
      out_verdict <= 1'b0;
      out_drop    <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      dl_q        <= dl_d;
      skip_q      <= skip_d;
      first_q     <= first_d;
      err_q       <= err_d;
      out_valid   <= ov_d;
      out_data    <= od_d;
      out_sof     <= os_d;
      out_eof     <= oe_d;
      out_err     <= oerr_d;
      out_verdict <= vv_d;
      out_drop    <= vd_d;
    end
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter int DA_BYTES  = 6,
  parameter int CRC_BYTES = 4,
  parameter int LEN_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_addr_lo,
  input  logic [CFG_W-1:0]  cfg_addr_hi,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_crc_err,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err,
  output logic              out_verdict,
  output logic              out_drop
);
  localparam int VEC_W = DA_BYTES * BYTE_W;

  rxf_ctl_t          ctl;
  logic [VEC_W-1:0]  station;
  logic [VEC_W-1:0]  taps;
  logic [VEC_W-1:0]  da;
  logic              reject;
  logic              shift_en;
  logic [BYTE_W-1:0] shift_din;

  assign ctl     = unpack_ctl(cfg_addr_hi);
  // R1: wire byte 0 is the low byte of the lower word
  assign station = {cfg_addr_hi[15:0], cfg_addr_lo};

  // destination bytes 0..DA_BYTES-2 sit in the line, the last is on the input
  genvar i;
  generate
    for (i = 0; i < DA_BYTES; i++) begin : g_da
      if (i == DA_BYTES - 1) begin : g_live
        assign da[i*BYTE_W +: BYTE_W] = in_data;
      end else begin : g_held
        assign da[i*BYTE_W +: BYTE_W] = taps[(DA_BYTES-2-i)*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  rxf_delay_line #(.DEPTH(DA_BYTES), .W(BYTE_W)) u_line (
    .clk      (clk),
    .shift_en (shift_en),
    .din      (shift_din),
    .taps     (taps)
  );

  rxf_addr_match #(.NB(DA_BYTES)) u_match (
    .da      (da),
    .station (station),
    .ctl     (ctl),
    .reject  (reject)
  );

  rxf_ctrl #(.DA_BYTES(DA_BYTES), .CRC_BYTES(CRC_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .max_len     (cfg_max_len),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .in_crc_err  (in_crc_err),
    .reject      (reject),
    .taps        (taps),
    .shift_en    (shift_en),
    .shift_din   (shift_din),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .out_err     (out_err),
    .out_verdict (out_verdict),
    .out_drop    (out_drop)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             len_chk,
  input logic [LEN_W-1:0] max_len,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic             out_err,
  input logic             out_verdict,
  input logic             out_drop
);
  logic             drop_seen;
  logic             accept_open;
  logic [LEN_W:0]   beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_seen   <= 1'b0;
      accept_open <= 1'b0;
      beats       <= '0;
    end else begin
      if (out_verdict) drop_seen <= out_drop;
      if (out_verdict && !out_drop) accept_open <= 1'b1;
      else if (out_valid && out_sof) accept_open <= 1'b0;
      if (out_valid) beats <= out_sof ? (LEN_W+1)'(1) : beats + 1'b1;
    end
  end

  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);                                     // R5
  AST_ERR_ONLY_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eof);                                       // R9
  AST_DROP_NEEDS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |-> out_verdict);                                  // R5
  AST_DROPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_seen |-> !out_valid);                                  // R6
  AST_SOF_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> accept_open);                    // R5
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof && len_chk) |-> (beats < {1'b0, max_len})); // R7
endmodule

bind rx_da_filter rxf_checker #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .len_chk     (cfg_addr_hi[rxf_pkg::HI_LEN_CHK]),
  .max_len     (cfg_max_len),
  .out_valid   (out_valid),
  .out_sof     (out_sof),
  .out_eof     (out_eof),
  .out_err     (out_err),
  .out_verdict (out_verdict),
  .out_drop    (out_drop)
);

// File: tb/sim_rx_da_filter.sv
module sim_rx_da_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_addr_lo, cfg_addr_hi;
  logic [13:0] cfg_max_len;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_crc_err = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid, out_sof, out_eof, out_err, out_verdict, out_drop;
  logic [7:0]  out_data;

  always #10 clk = ~clk;  // 50 MHz

  rx_da_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_max_len(cfg_max_len), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_err(in_crc_err),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_err(out_err), .out_verdict(out_verdict),
    .out_drop(out_drop)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // control state mirrored in the bench
  bit b_uc, b_bc, b_mc, b_lc, b_strip, b_ign;
  int b_max = 16383;
  byte unsigned station [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};

  // expected streams
  byte unsigned exp_data [$];
  bit           exp_sof [$], exp_eof [$], exp_err [$];
  string        exp_tag [$];
  bit           exp_vdrop [$];
  string        exp_vtag [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic apply_cfg();
    cfg_addr_lo = {station[3], station[2], station[1], station[0]};
    cfg_addr_hi = {10'd0, b_ign, b_strip, b_lc, b_mc, b_bc, b_uc, station[5], station[4]};
    cfg_max_len = 14'(b_max);
  endtask

  // behavioural reference: builds the expected beats and verdict of one frame
  task automatic model(input byte unsigned f [], input bit crc, input string tag);
    int  len = f.size();
    bit  bc, mc, uc, hit, drop;
    int  nout;
    bit  err;
    if (len < 6) begin
      exp_vdrop.push_back(1'b1); exp_vtag.push_back(tag);
      return;
    end
    bc = 1; hit = 1;
    for (int i = 0; i < 6; i++) begin
      if (f[i] != 8'hFF) bc = 0;
      if (f[i] != station[i]) hit = 0;
    end
    mc = f[0][0] && !bc;
    uc = !f[0][0];
    drop = (b_bc && bc) || (b_mc && mc) || (b_uc && uc && !hit);
    exp_vdrop.push_back(drop); exp_vtag.push_back(tag);
    if (drop) return;
    if (b_lc && len > b_max) begin
      nout = b_max; err = 1;
    end else begin
      nout = b_strip ? len - 4 : len;
      err  = crc && !b_ign;
    end
    for (int i = 0; i < nout; i++) begin
      exp_data.push_back(f[i]);
      exp_sof.push_back(i == 0);
      exp_eof.push_back(i == nout - 1);
      exp_err.push_back((i == nout - 1) && err);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic send(input byte unsigned f [], input bit crc, input string tag,
                      input bit bubbles);
    model(f, crc, tag);
    foreach (f[i]) begin
      @(posedge clk); #2;
      in_valid = 1; in_data = f[i]; in_sof = (i == 0);
      in_eof = (i == f.size() - 1); in_crc_err = crc && (i == f.size() - 1);
      if (bubbles && (i % 3 == 1)) begin
        @(posedge clk); #2;
        in_valid = 0;
        @(posedge clk); #2;
        in_valid = 1; in_data = f[i + 1 < f.size() ? i : i];
        in_valid = 0;
      end
    end
    @(posedge clk); #2;
    in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0;
    repeat (10) @(posedge clk);
  endtask

  function automatic void mkframe(ref byte unsigned f [], input int len,
                                  input byte unsigned da [6], input int seed);
    f = new[len];
    for (int i = 0; i < len; i++) f[i] = (i < 6) ? da[i] : byte'((i * 7 + seed) & 8'hFF);
  endfunction

  // compare against the reference on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (exp_data.size() == 0) begin
          check(0, "R5", "unexpected beat", out_data, 0);
        end else begin
          automatic string t = exp_tag.pop_front();
          automatic byte unsigned d = exp_data.pop_front();
          automatic bit s = exp_sof.pop_front();
          automatic bit e = exp_eof.pop_front();
          automatic bit r = exp_err.pop_front();
          check(out_data == d, t, "data", out_data, d);
          check(out_sof == s && out_eof == e, t, "sof/eof (R5)", {out_sof, out_eof}, {s, e});
          check(out_err == r, t, "err (R9)", out_err, r);
        end
      end
      if (out_verdict) begin
        if (exp_vdrop.size() == 0) begin
          check(0, "R5", "unexpected verdict", out_drop, 0);
        end else begin
          automatic string t = exp_vtag.pop_front();
          automatic bit v = exp_vdrop.pop_front();
          check(out_drop == v, t, "verdict drop (R5)", out_drop, v);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    automatic byte unsigned f [];
    automatic byte unsigned me [6]   = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    automatic byte unsigned other [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56};
    automatic byte unsigned bcast [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    automatic byte unsigned mcast [6] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
    apply_cfg();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && out_verdict == 0, "R11", "reset outputs",
          {out_valid, out_verdict}, 0);

    b_uc = 1; apply_cfg();
    mkframe(f, 20, me, 1);    send(f, 0, "R1", 0);
    mkframe(f, 20, other, 2); send(f, 0, "R2", 0);
    b_uc = 0; apply_cfg();
    mkframe(f, 20, other, 3); send(f, 0, "R2", 0);

    b_uc = 1; b_bc = 1; apply_cfg();
    mkframe(f, 18, bcast, 4); send(f, 0, "R3", 0);
    b_bc = 0; b_mc = 1; apply_cfg();
    mkframe(f, 18, bcast, 5); send(f, 0, "R3", 0);
    mkframe(f, 18, mcast, 6); send(f, 0, "R4", 0);
    b_mc = 0; apply_cfg();
    mkframe(f, 18, mcast, 7); send(f, 0, "R4", 0);

    mkframe(f, 4, me, 8);     send(f, 0, "R6", 0);
    mkframe(f, 1, me, 9);     send(f, 0, "R6", 0);
    mkframe(f, 6, me, 10);    send(f, 0, "R5", 0);

    b_strip = 1; apply_cfg();
    mkframe(f, 30, me, 11);   send(f, 0, "R8", 0);
    mkframe(f, 6, me, 12);    send(f, 0, "R8", 0);
    b_strip = 0; apply_cfg();

    mkframe(f, 20, me, 13);   send(f, 1, "R9", 0);
    b_ign = 1; apply_cfg();
    mkframe(f, 20, me, 14);   send(f, 1, "R9", 0);
    b_ign = 0; apply_cfg();

    b_lc = 1; b_max = 24; apply_cfg();
    mkframe(f, 40, me, 15);   send(f, 0, "R7", 0);
    mkframe(f, 25, me, 16);   send(f, 1, "R7", 0);
    mkframe(f, 24, me, 17);   send(f, 0, "R7", 0);
    b_lc = 0; apply_cfg();
    mkframe(f, 40, me, 18);   send(f, 0, "R7", 0);

    mkframe(f, 21, me, 19);   send(f, 0, "R10", 1);

    repeat (20) @(posedge clk);
    @(negedge clk);
    check(exp_data.size() == 0, "R5", "missing beats", exp_data.size(), 0);
    check(exp_vdrop.size() == 0, "R5", "missing verdicts", exp_vdrop.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule